// File: doc/BRIEF.md
# Watchdog Kick Handover Controller

This block drives the trigger input of an external supervisor watchdog. After power-on reset it kicks the watchdog by itself with a fixed-period pulse. This keeps the supervisor satisfied while the FPGA fabric is still configuring and booting.

The FPGA takes over by raising its enable level and issuing hit pulses. After sixteen qualified hits, the block hands control to the FPGA at the next gap between its own pulses. From then on, FPGA hits are passed straight to the trigger pin. The handover is permanent until the next reset, and the FPGA enable level no longer has any effect. A sticky flag reports any forwarded pulse that is long enough to risk a supervisor timeout.

All timing is derived from a clock-frequency parameter:

- Self-kick period: 1 ms.
- Self-kick high time: 507 us, rounded down to whole cycles and never less than 300 ns.
- Supervisor minimum timeout: 0.55 s.

Top module: `wdk_top`

## Requirements
- R1: After reset release, wd_kick_o rises on the first clock edge. While not handed over, it then repeats a pulse that is high for HIGH_CYC cycles in every PERIOD_CYC cycles. PERIOD_CYC = floor(CLK_HZ·1 ms). HIGH_CYC = max(floor(CLK_HZ·507 us), ceil(CLK_HZ·300 ns)). At CLK_HZ = 100000 these are 100 and 50.
- R2: Both inputs pass through a two-flop synchronizer. Only a rising edge of the synchronized hit, seen while the synchronized enable is high, advances the hit count. The count saturates at 16 and returns to zero whenever the enable is low before handover.
- R3: handover_o becomes 1 only when the enable is high and 16 hits are counted. It becomes 1 at the first such cycle in which the self-kick pulse is low.
- R4: Once handover_o is 1, wd_kick_o equals wd_hit_i delayed by exactly three clock cycles.
- R5: Once handover_o is 1, wd_en_i has no effect, and handover_o stays 1 until rst_ni is asserted.
- R6: In the cycle handover_o rises, wd_kick_o is low, so no self-kick pulse is cut short or joined to a forwarded one.
- R7: pulse_viol_o is set when a forwarded pulse stays high for more than LIMIT = TMO_CYC − HIGH_CYC cycles, where TMO_CYC = floor(CLK_HZ·0.55 s). A pulse of exactly LIMIT cycles leaves it clear. Once set, it stays set until reset. At CLK_HZ = 100000, LIMIT = 54950.
- R8: While rst_ni is low, wd_kick_o, handover_o and pulse_viol_o are all 0.
- R9: Hits seen while the enable is low, and fewer than 16 hits with the enable high, never cause handover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| wd_en_i | input | 1 | FPGA watchdog-enable level (asynchronous) |
| wd_hit_i | input | 1 | FPGA hit pulse line (asynchronous) |
| wd_kick_o | output | 1 | Trigger to the external supervisor |
| handover_o | output | 1 | FPGA owns the trigger |
| pulse_viol_o | output | 1 | Sticky: forwarded pulse exceeded the allowed width |

## Verification
Faults in the self-kick counter show up within one period as a wrong high or low width on the trigger pin. Faults in the hit counter, or in its clearing, show up as a handover that comes too early, too late or never. This is visible on handover_o within one period after the hit burst. Faults in the output path after handover show up on the next hit edge, which the bench compares cycle by cycle against a three-cycle delayed copy of its own stimulus. Faults in the width guard show up only at the boundary pulse lengths LIMIT and LIMIT+1, so both lengths are driven.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

  typedef enum logic {
    CTRL_SELF = 1'b0,
    CTRL_FPGA = 1'b1
  } ctrl_e;

  function automatic int unsigned ns_to_cyc_floor(longint unsigned hz, longint unsigned ns);
    longint unsigned p;
    p = (hz * ns) / 64'd1_000_000_000;
    return p[31:0];
  endfunction

  function automatic int unsigned ns_to_cyc_ceil(longint unsigned hz, longint unsigned ns);
    longint unsigned p;
    p = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    return p[31:0];
  endfunction

endpackage

// File: rtl/wdk_sync.sv
module wdk_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q[0] <= '0;
    else         st_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[g] <= '0;
      else         st_q[g] <= st_q[g-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/wdk_self_kick.sv
module wdk_self_kick #(
  parameter int unsigned PERIOD_CYC = 100,
  parameter int unsigned HIGH_CYC   = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic pulse_o,
  output logic idle_o
);
  localparam int PW = $clog2(PERIOD_CYC);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (cnt_q == PW'(PERIOD_CYC-1)) cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end

  assign pulse_o = (cnt_q < PW'(HIGH_CYC));
  assign idle_o  = ~pulse_o;

  // R1
  period_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_q) == PW'(PERIOD_CYC-1)) |-> (cnt_q == '0 && pulse_o));
endmodule

// File: rtl/wdk_hit_qual.sv
module wdk_hit_qual #(
  parameter int unsigned HITS_REQ = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hit_i,
  input  logic freeze_i,
  output logic ready_o
);
  localparam int CW = $clog2(HITS_REQ + 1);

  logic [CW-1:0] cnt_q;
  logic          hit_d_q;
  logic          rise;

  assign rise = hit_i & ~hit_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_d_q <= 1'b0;
    else         hit_d_q <= hit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  cnt_q <= '0;
    else if (freeze_i)                            cnt_q <= cnt_q;
    else if (!en_i)                               cnt_q <= '0;
    else if (rise && cnt_q != CW'(HITS_REQ))      cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = en_i && (cnt_q == CW'(HITS_REQ));

  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1));

  // R2
  count_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!en_i) && $past(!freeze_i)) |-> (cnt_q == '0));

  // R2
  count_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(HITS_REQ));
endmodule

// File: rtl/wdk_pulse_guard.sv
module wdk_pulse_guard #(
  parameter int unsigned LIMIT = 54950
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic pulse_i,
  output logic viol_o
);
  localparam int WW = $clog2(LIMIT + 1);

  logic [WW-1:0] w_q;
  logic          viol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q    <= '0;
      viol_q <= 1'b0;
    end else if (arm_i && pulse_i) begin
      if (w_q != WW'(LIMIT)) w_q <= w_q + 1'b1;
      else                   viol_q <= 1'b1;
    end else begin
      w_q <= '0;
    end
  end

  assign viol_o = viol_q;

  // R7
  viol_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(viol_q) |-> viol_q);

  // R7
  viol_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(viol_q) |-> ($past(arm_i) && $past(pulse_i)));
endmodule

// File: rtl/wdk_top.sv
module wdk_top #(
  parameter int unsigned CLK_HZ       = 100_000_000,
  parameter int unsigned PERIOD_NS    = 1_000_000,
  parameter int unsigned HIGH_NS      = 507_000,
  parameter int unsigned MIN_HIGH_NS  = 300,
  parameter int unsigned TMO_MIN_NS   = 550_000_000,
  parameter int unsigned HITS_REQ     = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wd_en_i,
  input  logic wd_hit_i,
  output logic wd_kick_o,
  output logic handover_o,
  output logic pulse_viol_o
);
  import wdk_pkg::*;

  localparam int unsigned PERIOD_CYC = ns_to_cyc_floor(64'(CLK_HZ), 64'(PERIOD_NS));
  localparam int unsigned HIGH_RAW   = ns_to_cyc_floor(64'(CLK_HZ), 64'(HIGH_NS));
  localparam int unsigned HIGH_MIN   = ns_to_cyc_ceil(64'(CLK_HZ), 64'(MIN_HIGH_NS));
  localparam int unsigned HIGH_CYC   = (HIGH_RAW > HIGH_MIN) ? HIGH_RAW : HIGH_MIN;
  localparam int unsigned TMO_CYC    = ns_to_cyc_floor(64'(CLK_HZ), 64'(TMO_MIN_NS));
  localparam int unsigned LIMIT_CYC  = TMO_CYC - HIGH_CYC;

  logic [1:0] sync_s;
  logic       en_s, hit_s;
  logic       self_pulse, self_idle;
  logic       ready;
  ctrl_e      mode_q;
  logic       kick_q;
  logic       fpga_own;

  wdk_sync #(.W(2), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wd_en_i, wd_hit_i}),
    .q_o   (sync_s)
  );
  assign en_s  = sync_s[1];
  assign hit_s = sync_s[0];

  wdk_self_kick #(.PERIOD_CYC(PERIOD_CYC), .HIGH_CYC(HIGH_CYC)) u_self (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pulse_o(self_pulse),
    .idle_o (self_idle)
  );

  assign fpga_own = (mode_q == CTRL_FPGA);

  wdk_hit_qual #(.HITS_REQ(HITS_REQ)) u_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_s),
    .hit_i   (hit_s),
    .freeze_i(fpga_own),
    .ready_o (ready)
  );

  // handover waits for a gap in the self pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        mode_q <= CTRL_SELF;
    else if (!fpga_own && ready && self_idle) mode_q <= CTRL_FPGA;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       kick_q <= 1'b0;
    else if (fpga_own) kick_q <= hit_s;
    else               kick_q <= self_pulse;
  end

  wdk_pulse_guard #(.LIMIT(LIMIT_CYC)) u_guard (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (fpga_own),
    .pulse_i(kick_q),
    .viol_o (pulse_viol_o)
  );

  assign wd_kick_o  = kick_q;
  assign handover_o = fpga_own;

  // R3
  handover_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fpga_own) |-> $past(ready));

  // R5
  handover_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fpga_own |=> fpga_own);

  // R6
  no_trunc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fpga_own) |-> !kick_q);

  // R4
  fwd_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fpga_own && $past(fpga_own)) |-> (kick_q == $past(hit_s)));
endmodule

// File: tb/wdk_top_test.sv
module wdk_top_test;
  localparam int unsigned TB_HZ    = 100_000;
  localparam int          EXP_PER  = 100;
  localparam int          EXP_HIGH = 50;
  localparam int          EXP_LIM  = 54950;

  logic clk = 1'b0;
  logic rst_ni, wd_en_i, wd_hit_i;
  logic wd_kick_o, handover_o, pulse_viol_o;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  typedef struct { int at; logic val; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdk_top #(.CLK_HZ(TB_HZ)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .wd_en_i     (wd_en_i),
    .wd_hit_i    (wd_hit_i),
    .wd_kick_o   (wd_kick_o),
    .handover_o  (handover_o),
    .pulse_viol_o(pulse_viol_o)
  );

  task automatic check(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic hit_pulse(int hi, int lo);
    wd_hit_i = 1'b1;
    repeat (hi) tick();
    wd_hit_i = 1'b0;
    repeat (lo) tick();
  endtask

  task automatic drive_hit(logic v);
    wd_hit_i = v;
    exp_q.push_back('{at: cyc + 3, val: v});
    tick();
  endtask

  task automatic measure(output int hi, output int lo);
    hi = 0;
    lo = 0;
    while (wd_kick_o !== 1'b0) tick();
    while (wd_kick_o !== 1'b1) tick();
    while (wd_kick_o === 1'b1) begin hi++; tick(); end
    while (wd_kick_o === 1'b0) begin lo++; tick(); end
  endtask

  // scoreboard monitor
  always begin
    @(posedge clk);
    #2;
    while (exp_q.size() > 0 && exp_q[0].at == cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      check("R4 forwarded kick", int'(wd_kick_o), int'(e.val));
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired (all R) act=%0d exp=0", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int hi, lo, waited;
    rst_ni = 1'b0; wd_en_i = 1'b0; wd_hit_i = 1'b0;
    repeat (3) tick();
    check("R8 kick in reset", int'(wd_kick_o), 0);
    check("R8 handover in reset", int'(handover_o), 0);
    check("R8 viol in reset", int'(pulse_viol_o), 0);

    rst_ni = 1'b1;
    tick();
    check("R1 first rise", int'(wd_kick_o), 1);
    measure(hi, lo);
    check("R1 self high", hi, EXP_HIGH);
    check("R1 self low", lo, EXP_PER - EXP_HIGH);

    // R9: hits with enable low
    repeat (20) hit_pulse(2, 2);
    repeat (2 * EXP_PER) tick();
    check("R9 no handover enable low", int'(handover_o), 0);

    // R2: enable drop clears the count
    wd_en_i = 1'b1;
    repeat (3) tick();
    repeat (10) hit_pulse(2, 2);
    wd_en_i = 1'b0;
    repeat (4) tick();
    wd_en_i = 1'b1;
    repeat (3) tick();
    repeat (10) hit_pulse(2, 2);
    repeat (2 * EXP_PER) tick();
    check("R2 count cleared by enable low", int'(handover_o), 0);
    measure(hi, lo);
    check("R1 self high before handover", hi, EXP_HIGH);

    // R9: 15 hits are not enough
    repeat (5) hit_pulse(2, 2);
    repeat (2 * EXP_PER) tick();
    check("R9 fifteen hits", int'(handover_o), 0);

    // R3: sixteenth hit
    hit_pulse(2, 0);
    waited = 0;
    while (handover_o !== 1'b1 && waited < 3 * EXP_PER) begin tick(); waited++; end
    check("R3 handover after 16 hits", int'(handover_o), 1);
    check("R3 handover within a period", int'(waited <= EXP_PER), 1);
    check("R6 kick low at handover", int'(wd_kick_o), 0);

    // R4/R5: forwarding with enable low
    wd_en_i = 1'b0;
    for (int w = 1; w <= 4; w++) begin
      for (int k = 0; k < w; k++) drive_hit(1'b1);
      for (int k = 0; k < w; k++) drive_hit(1'b0);
    end
    wd_en_i = 1'b1;
    drive_hit(1'b1);
    wd_en_i = 1'b0;
    drive_hit(1'b1);
    drive_hit(1'b0);
    repeat (5) tick();
    check("R4 scoreboard drained", exp_q.size(), 0);
    repeat (3 * EXP_PER) tick();
    check("R5 handover kept, enable low", int'(handover_o), 1);
    check("R5 no self kick after handover", int'(wd_kick_o), 0);

    // R7: boundary widths
    wd_hit_i = 1'b1;
    repeat (EXP_LIM) tick();
    wd_hit_i = 1'b0;
    repeat (10) tick();
    check("R7 no viol at limit", int'(pulse_viol_o), 0);
    wd_hit_i = 1'b1;
    repeat (EXP_LIM + 1) tick();
    wd_hit_i = 1'b0;
    repeat (10) tick();
    check("R7 viol above limit", int'(pulse_viol_o), 1);
    repeat (20) tick();
    check("R7 viol sticky", int'(pulse_viol_o), 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule